// File: doc/BRIEF.md
# Priority Interrupt Selector

This block picks the interrupt a processor core should take next, once no trap is waiting. It merges two request sources across priority levels 1 to 7: software-programmed request bits held in a programmed-interrupt register, and per-level request lines from external bus devices, each line paired with its own vector. Only levels strictly above the current processor priority are eligible.

The highest eligible level wins. Within one level the software request beats the bus request. A software win always yields the fixed vector 0xA0. A bus win yields the vector that device supplies and a one-cycle acknowledge to that level. If the wait input is high at that moment, it also yields a wake pulse. When the level scan finds nothing, a fallback compares the level field in bits 3:1 of the programmed-interrupt register with the processor priority and takes vector 0xA0 if the field is greater.

Results are registered. The caller fetches the vector and pushes state; this block does neither.

Top module: `irq_select`

## Requirements
- R1: While trap_pend_i is high, no interrupt is taken: take_o, ack_o and wake_o stay low in the following cycle.
- R2: Among eligible levels (level greater than prio_i), the highest level holding any request wins.
- R3: At the winning level, a software request (pirq_i bit 8+level) is chosen over the bus request at that level; it yields vec_o = 0xA0 and no acknowledge.
- R4: A bus win at level L yields vec_o = bus_vec_i[(L-1)*16 +: 16] and ack_o with only bit L-1 set.
- R5: Requests at or below prio_i are ignored: no take, no acknowledge, no wake.
- R6: With no eligible level request, a take with vec_o = 0xA0 and no acknowledge occurs when pirq_i[3:1] > prio_i; a level-scan hit takes precedence over this fallback.
- R7: wake_o pulses together with a bus acknowledge when wait_i was high; a software or fallback take never wakes.
- R8: Outputs change one clock edge after the inputs are sampled. A cycle with take_o high is always followed by one with take_o low, so the acknowledge to a level is a single-cycle pulse even if its request stays high.
- R9: Reset clears all outputs at once. Whenever take_o is low, vec_o, ack_o and wake_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_pend_i | input | 1 | A trap is waiting; blocks selection |
| wait_i | input | 1 | Core is in its wait state |
| prio_i | input | 3 | Current processor priority |
| pirq_i | input | 16 | Programmed-interrupt register; bit 8+L requests level L, bits 3:1 hold the fallback level |
| bus_req_i | input | 7 | Bus request lines; bit L-1 is level L |
| bus_vec_i | input | 112 | Bus vectors; level L at bits (L-1)*16 +: 16 |
| take_o | output | 1 | Interrupt taken this cycle |
| vec_o | output | 16 | Vector of the taken interrupt |
| ack_o | output | 7 | One-hot acknowledge to the chosen bus level |
| wake_o | output | 1 | Move from waiting to running |

## Verification
All four results come out of one register stage, so each is due exactly one rising edge after the inputs that cause it. The bench changes inputs on the falling edge and reads results at the next falling edge. Between table rows it inserts one idle cycle, so the hold-off cycle after a take never hides a result. Directed tests confirm that the outputs do not move before that edge, and that a steady request produces takes on alternating cycles.

// File: rtl/irq_select_pkg.sv
package irq_select_pkg;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_SOFT  = 2'd1,
    SRC_BUS   = 2'd2,
    SRC_FBACK = 2'd3
  } src_e;

  // a level competes only when strictly above the running priority
  function automatic bit above_prio(int lvl, int prio);
    return lvl > prio;
  endfunction

  // position of the software request bit for a level
  function automatic int soft_bit(int base, int lvl);
    return base + lvl;
  endfunction

endpackage

// File: rtl/irq_level_scan.sv
module irq_level_scan
  import irq_select_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int PIRQ_W     = 16,
  parameter int SOFT_BASE  = 8,
  localparam int PRIO_W    = $clog2(NUM_LEVELS),
  localparam int NREQ      = NUM_LEVELS - 1
) (
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [PIRQ_W-1:0] pirq_i,
  input  logic [NREQ-1:0]   bus_req_i,
  output logic              hit_o,
  output logic              soft_o,
  output logic [PRIO_W-1:0] lvl_o
);

  logic [NUM_LEVELS-1:1] elig;
  logic [NUM_LEVELS-1:1] soft_hit;
  logic [NUM_LEVELS-1:1] any_hit;

  for (genvar g = 1; g < NUM_LEVELS; g++) begin : g_lvl
    assign elig[g]     = above_prio(g, int'(prio_i));
    assign soft_hit[g] = elig[g] & pirq_i[soft_bit(SOFT_BASE, g)];
    assign any_hit[g]  = soft_hit[g] | (elig[g] & bus_req_i[g-1]);
  end

  // ascending walk: the last hit seen is the highest level
  always_comb begin
    hit_o  = 1'b0;
    soft_o = 1'b0;
    lvl_o  = '0;
    for (int l = 1; l < NUM_LEVELS; l++) begin
      if (any_hit[l]) begin
        hit_o  = 1'b1;
        soft_o = soft_hit[l];
        lvl_o  = PRIO_W'(l);
      end
    end
  end

endmodule

// File: rtl/irq_soft_fallback.sv
module irq_soft_fallback #(
  parameter int NUM_LEVELS = 8,
  parameter int PIRQ_W     = 16,
  localparam int PRIO_W    = $clog2(NUM_LEVELS)
) (
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [PIRQ_W-1:0] pirq_i,
  output logic              hit_o
);

  logic [PRIO_W-1:0] fb_lvl;

  assign fb_lvl = pirq_i[PRIO_W:1];
  assign hit_o  = fb_lvl > prio_i;

endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_select_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int VEC_W      = 16,
  parameter int PIRQ_W     = 16,
  parameter int SOFT_BASE  = 8,
  parameter int SOFT_VEC   = 'hA0,
  localparam int PRIO_W    = $clog2(NUM_LEVELS),
  localparam int NREQ      = NUM_LEVELS - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trap_pend_i,
  input  logic                  wait_i,
  input  logic [PRIO_W-1:0]     prio_i,
  input  logic [PIRQ_W-1:0]     pirq_i,
  input  logic [NREQ-1:0]       bus_req_i,
  input  logic [NREQ*VEC_W-1:0] bus_vec_i,
  output logic                  take_o,
  output logic [VEC_W-1:0]      vec_o,
  output logic [NREQ-1:0]       ack_o,
  output logic                  wake_o
);

  localparam logic [VEC_W-1:0] SOFT_V = VEC_W'(SOFT_VEC);

  logic              scan_hit;
  logic              scan_soft;
  logic [PRIO_W-1:0] scan_lvl;
  logic              fb_hit;
  src_e              src_n;
  logic [VEC_W-1:0]  bus_vec_sel;
  logic [VEC_W-1:0]  vec_n;
  logic [NREQ-1:0]   ack_n;

  irq_level_scan #(
    .NUM_LEVELS(NUM_LEVELS), .PIRQ_W(PIRQ_W), .SOFT_BASE(SOFT_BASE)
  ) u_scan (
    .prio_i(prio_i), .pirq_i(pirq_i), .bus_req_i(bus_req_i),
    .hit_o(scan_hit), .soft_o(scan_soft), .lvl_o(scan_lvl)
  );

  irq_soft_fallback #(
    .NUM_LEVELS(NUM_LEVELS), .PIRQ_W(PIRQ_W)
  ) u_fb (
    .prio_i(prio_i), .pirq_i(pirq_i), .hit_o(fb_hit)
  );

  // source choice; a take in the previous cycle forces one idle cycle
  always_comb begin
    if (trap_pend_i || take_o)  src_n = SRC_NONE;
    else if (scan_hit)          src_n = scan_soft ? SRC_SOFT : SRC_BUS;
    else if (fb_hit)            src_n = SRC_FBACK;
    else                        src_n = SRC_NONE;
  end

  always_comb begin
    bus_vec_sel = '0;
    ack_n       = '0;
    for (int l = 1; l < NUM_LEVELS; l++) begin
      if (scan_lvl == PRIO_W'(l)) begin
        bus_vec_sel  = bus_vec_i[(l-1)*VEC_W +: VEC_W];
        ack_n[l-1]   = (src_n == SRC_BUS);
      end
    end
  end

  always_comb begin
    unique case (src_n)
      SRC_BUS:   vec_n = bus_vec_sel;
      SRC_SOFT,
      SRC_FBACK: vec_n = SOFT_V;
      default:   vec_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o <= 1'b0;
      vec_o  <= '0;
      ack_o  <= '0;
      wake_o <= 1'b0;
    end else begin
      take_o <= (src_n != SRC_NONE);
      vec_o  <= vec_n;
      ack_o  <= ack_n;
      wake_o <= (src_n == SRC_BUS) && wait_i;
    end
  end

endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk #(
  parameter int NUM_LEVELS = 8,
  parameter int VEC_W      = 16,
  parameter int SOFT_VEC   = 'hA0,
  localparam int PRIO_W    = $clog2(NUM_LEVELS),
  localparam int NREQ      = NUM_LEVELS - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trap_pend_i,
  input logic              wait_i,
  input logic [PRIO_W-1:0] prio_i,
  input logic              take_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic [NREQ-1:0]   ack_o,
  input logic              wake_o,
  input logic              scan_hit,
  input logic              scan_soft,
  input logic              fb_hit
);

  logic [PRIO_W-1:0] ack_lvl;
  always_comb begin
    ack_lvl = '0;
    for (int l = 1; l < NUM_LEVELS; l++)
      if (ack_o[l-1]) ack_lvl = PRIO_W'(l);
  end

  p_trap_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pend_i |=> (!take_o && ack_o == '0 && !wake_o));

  p_above_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_o) |-> (ack_lvl > $past(prio_i)));

  p_soft_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_o && !trap_pend_i && scan_hit && scan_soft) |=>
      (take_o && vec_o == VEC_W'(SOFT_VEC) && ack_o == '0));

  p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o) && ((|ack_o) -> take_o));

  p_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_hit && !fb_hit) |=> !take_o);

  p_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_o && !trap_pend_i && !scan_hit && fb_hit) |=>
      (take_o && vec_o == VEC_W'(SOFT_VEC) && ack_o == '0));

  p_wake_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> ((|ack_o) && $past(wait_i)));

  p_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (vec_o == '0 && ack_o == '0 && !wake_o));

endmodule

bind irq_select irq_select_chk #(
  .NUM_LEVELS(NUM_LEVELS), .VEC_W(VEC_W), .SOFT_VEC(SOFT_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_pend_i(trap_pend_i), .wait_i(wait_i),
  .prio_i(prio_i), .take_o(take_o), .vec_o(vec_o), .ack_o(ack_o),
  .wake_o(wake_o), .scan_hit(scan_hit), .scan_soft(scan_soft), .fb_hit(fb_hit)
);

// File: tb/irq_select_test.sv
`timescale 1ns/1ps
module irq_select_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         trap_pend_i = 1'b0;
  logic         wait_i = 1'b0;
  logic [2:0]   prio_i = '0;
  logic [15:0]  pirq_i = '0;
  logic [6:0]   bus_req_i = '0;
  logic [111:0] bus_vec_i;
  logic         take_o;
  logic [15:0]  vec_o;
  logic [6:0]   ack_o;
  logic         wake_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_select uut (
    .clk(clk), .rst_n(rst_n), .trap_pend_i(trap_pend_i), .wait_i(wait_i),
    .prio_i(prio_i), .pirq_i(pirq_i), .bus_req_i(bus_req_i),
    .bus_vec_i(bus_vec_i), .take_o(take_o), .vec_o(vec_o),
    .ack_o(ack_o), .wake_o(wake_o)
  );

  // device at level L answers with vector 0x100 + 4*L
  function automatic logic [15:0] dev_vec(int lvl);
    return 16'h100 + 16'(4 * lvl);
  endfunction

  typedef struct packed {
    logic [3:0]  req;
    logic        trap;
    logic        wt;
    logic [2:0]  prio;
    logic [15:0] pirq;
    logic [6:0]  breq;
    logic        etake;
    logic [15:0] evec;
    logic [6:0]  eack;
    logic        ewake;
  } row_t;

  localparam int NROWS = 12;
  localparam row_t TBL [NROWS] = '{
    '{4'd1, 1'b1, 1'b0, 3'd0, 16'h8000, 7'h7F, 1'b0, 16'h0000, 7'h00, 1'b0}, // R1 trap blocks all
    '{4'd2, 1'b0, 1'b0, 3'd2, 16'h0000, 7'h14, 1'b1, 16'h0114, 7'h10, 1'b0}, // R2 L5 over L3
    '{4'd3, 1'b0, 1'b0, 3'd2, 16'h2000, 7'h10, 1'b1, 16'h00A0, 7'h00, 1'b0}, // R3 soft beats bus at L5
    '{4'd2, 1'b0, 1'b0, 3'd2, 16'h1000, 7'h20, 1'b1, 16'h0118, 7'h20, 1'b0}, // R2 bus L6 over soft L4
    '{4'd5, 1'b0, 1'b1, 3'd5, 16'h2000, 7'h14, 1'b0, 16'h0000, 7'h00, 1'b0}, // R5 all at/below prio
    '{4'd6, 1'b0, 1'b0, 3'd2, 16'h0006, 7'h00, 1'b1, 16'h00A0, 7'h00, 1'b0}, // R6 fallback 3 > 2
    '{4'd6, 1'b0, 1'b0, 3'd3, 16'h0006, 7'h00, 1'b0, 16'h0000, 7'h00, 1'b0}, // R6 fallback 3 not > 3
    '{4'd7, 1'b0, 1'b1, 3'd0, 16'h0000, 7'h01, 1'b1, 16'h0104, 7'h01, 1'b1}, // R7 bus wakes
    '{4'd7, 1'b0, 1'b1, 3'd0, 16'h0200, 7'h00, 1'b1, 16'h00A0, 7'h00, 1'b0}, // R7 soft never wakes
    '{4'd4, 1'b0, 1'b0, 3'd6, 16'h0000, 7'h40, 1'b1, 16'h011C, 7'h40, 1'b0}, // R4 bus L7
    '{4'd6, 1'b0, 1'b0, 3'd1, 16'h000E, 7'h02, 1'b1, 16'h0108, 7'h02, 1'b0}, // R6 scan beats fallback
    '{4'd5, 1'b0, 1'b0, 3'd7, 16'hFF0E, 7'h7F, 1'b0, 16'h0000, 7'h00, 1'b0}  // R5 prio 7 masks all
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic go_idle();
    trap_pend_i = 1'b0; wait_i = 1'b0; prio_i = '0; pirq_i = '0; bus_req_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int l = 1; l <= 7; l++) bus_vec_i[(l-1)*16 +: 16] = dev_vec(l);
    // R9: reset holds outputs low even with active requests
    bus_req_i = 7'h7F;
    pirq_i = 16'hFF0E;
    repeat (2) @(negedge clk);
    chk("R9", "take in reset", 32'(take_o), 32'd0);
    chk("R9", "ack in reset", 32'(ack_o), 32'd0);
    chk("R9", "vec in reset", 32'(vec_o), 32'd0);
    go_idle();
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NROWS; i++) begin
      string rq;
      rq = $sformatf("R%0d", TBL[i].req);
      trap_pend_i = TBL[i].trap;
      wait_i      = TBL[i].wt;
      prio_i      = TBL[i].prio;
      pirq_i      = TBL[i].pirq;
      bus_req_i   = TBL[i].breq;
      @(negedge clk);
      chk(rq, "take", 32'(take_o), 32'(TBL[i].etake));
      chk(rq, "vec",  32'(vec_o),  32'(TBL[i].evec));
      chk(rq, "ack",  32'(ack_o),  32'(TBL[i].eack));
      chk(rq, "wake", 32'(wake_o), 32'(TBL[i].ewake));
      go_idle();
      @(negedge clk);
    end

    // R8: registered latency and alternating takes under a steady request
    bus_req_i = 7'h08;
    #1;
    chk("R8", "no same-cycle take", 32'(take_o), 32'd0);
    @(negedge clk);
    chk("R8", "first take", 32'(take_o), 32'd1);
    chk("R8", "first ack L4", 32'(ack_o), 32'h08);
    @(negedge clk);
    chk("R8", "hold-off take", 32'(take_o), 32'd0);
    chk("R8", "hold-off ack", 32'(ack_o), 32'd0);
    @(negedge clk);
    chk("R8", "second take", 32'(take_o), 32'd1);
    chk("R4", "second vec L4", 32'(vec_o), 32'(dev_vec(4)));

    // R9: asynchronous reset clears a live take immediately
    rst_n = 1'b0;
    #1;
    chk("R9", "async clear take", 32'(take_o), 32'd0);
    chk("R9", "async clear vec", 32'(vec_o), 32'd0);
    go_idle();
    @(negedge clk);
    rst_n = 1'b1;

    // R1: trap raised while software request waits, then dropped
    pirq_i = 16'h4000;
    trap_pend_i = 1'b1;
    @(negedge clk);
    chk("R1", "trap holds off soft L6", 32'(take_o), 32'd0);
    trap_pend_i = 1'b0;
    @(negedge clk);
    chk("R1", "taken after trap clears", 32'(vec_o), 32'h00A0);
    go_idle();
    @(negedge clk);

    finish_run();
  end

endmodule